// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. It time-shares one memory port and one ALU. A single memory address drives both the instruction fetch and the data accesses. Every value that the memory, the register file or the ALU produces is captured in a holding register, and a later cycle reads it from there. The holding registers are the program counter, the instruction register, the memory data register, the two operand registers and the ALU result register.

A separate control sequencer drives the block, one step per clock. On every cycle it sets the write enables, the multiplexer selects and the ALU operation. In return it reads the opcode, the function field and the ALU zero flag. The memory outside the block reads asynchronously from the address it is given and takes its write data from the B operand register.

All the select and operation inputs are plain vectors. The encodings listed in the requirements are the contract with the sequencer.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held, the PC, IR, MDR, A, B, ALU result register and every register-file entry are zero. `mem_addr`, `opcode`, `funct` and `mem_wdata` read 0.
- R2: IR loads `mem_rdata` on a clock edge only when `ir_we` is 1, and holds its value otherwise. `opcode` is IR[31:26] and `funct` is IR[5:0].
- R3: `mem_addr` is the PC when `addr_sel`=0 and the ALU result register when `addr_sel`=1.
- R4: `alu_op` encodings: 0 add, 1 subtract (A−B), 2 AND, 3 OR, 4 signed set-on-less-than giving 1 or 0 in bit 0. The ALU result is latched into the ALU result register at every clock edge.
- R5: `zero` is 1 exactly when the current ALU result is 0. With subtract on A and B, this means A equals B.
- R6: Register 0 always reads as zero, and a write aimed at it has no effect.
- R7: When `rf_we`=1, the register file writes on the clock edge. The destination is IR[20:16] when `dst_sel`=0 and IR[15:11] when `dst_sel`=1. The data is the ALU result register when `wb_sel`=0 and MDR when `wb_sel`=1.
- R8: A and B load, on every clock edge, the register-file entries named by IR[25:21] and IR[20:16]. `mem_wdata` always shows B.
- R9: The first ALU operand is the PC when `srca_sel`=0 and A when `srca_sel`=1. The second operand depends on `srcb_sel`: 0 selects B, 1 the constant 4, 2 IR[15:0] sign-extended, and 3 that sign-extended value shifted left by two.
- R10: The PC loads a new value when `pc_we`=1, or when `pc_we_cond`=1 and `zero`=1. In every other cycle it holds.
- R11: `pc_src` picks the PC's next value: 0 selects the live ALU result, 1 the ALU result register, and 2 the jump target {PC[31:28], IR[25:0], 2'b00}. A jump never changes PC[31:28].
- R12: MDR loads `mem_rdata` at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write qualified by the zero flag |
| addr_sel | input | 1 | Memory address source (0 PC, 1 ALU result register) |
| ir_we | input | 1 | Instruction register load enable |
| rf_we | input | 1 | Register-file write enable |
| dst_sel | input | 1 | Destination field (0 rt, 1 rd) |
| wb_sel | input | 1 | Write-back source (0 ALU result register, 1 MDR) |
| srca_sel | input | 1 | First ALU operand (0 PC, 1 A) |
| srcb_sel | input | 2 | Second ALU operand select |
| alu_op | input | 3 | ALU operation |
| pc_src | input | 2 | PC next-value source |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (B register) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | ALU result is zero |

## Verification
The ALU is swept over every pair drawn from eight operands: zero, one, minus one, both signed extremes, small values of each sign and a mixed pattern. The pairs that straddle the sign boundary are where a signed set-on-less-than and an unsigned one disagree. Pairs with equal operands separate a correct zero flag from one that is stuck or inverted. Writes into register 0 and writes through each destination and write-back select show whether the data reached the right entry from the right source. The PC is exercised with a branch in both outcomes, an immediate with a negative sign, and a jump taken from a PC whose upper four bits are nonzero, which shows whether the region bits are kept.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG    = 2'd0,
        SRCB_FOUR   = 2'd1,
        SRCB_IMM    = 2'd2,
        SRCB_IMM_X4 = 2'd3
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'd0,
        PCS_ALUREG = 2'd1,
        PCS_JUMP   = 2'd2
    } pcsrc_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_addr_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_a,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] store_q [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) store_q[i] <= '0;
        end else if (wr_en && (wr_addr != '0)) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data_a = (rd_addr_a == '0) ? '0 : store_q[rd_addr_a];
    assign rd_data_b = (rd_addr_b == '0) ? '0 : store_q[rd_addr_b];

    // R6: entry zero never holds anything but zero
    a_r6_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
        store_q[0] == '0);

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] result,
    output logic            is_zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_SUB: result = opnd_a - opnd_b;
            ALU_AND: result = opnd_a & opnd_b;
            ALU_OR:  result = opnd_a | opnd_b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))};
            default: result = '0;
        endcase
    end

    assign is_zero = (result == '0);

    // R4: set-on-less-than only ever drives bit 0
    a_r4_slt_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ALU_SLT) |-> (result[XLEN-1:1] == '0));

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import dp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic            pc_we_cond,
    input  logic            addr_sel,
    input  logic            ir_we,
    input  logic            rf_we,
    input  logic            dst_sel,
    input  logic            wb_sel,
    input  logic            srca_sel,
    input  logic [1:0]      srcb_sel,
    input  logic [2:0]      alu_op,
    input  logic [1:0]      pc_src,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [5:0]      opcode,
    output logic [5:0]      funct,
    output logic            zero
);

    localparam int AW   = $clog2(NREGS);
    localparam int IMMW = 16;

    logic [XLEN-1:0] pc_q, mdr_q, a_q, b_q, aluout_q;
    logic [31:0]     ir_q;
    logic [XLEN-1:0] rf_a, rf_b, wb_data;
    logic [AW-1:0]   wb_addr;
    logic [XLEN-1:0] opnd_a, opnd_b, alu_res, imm_ext, jump_tgt, pc_next;
    logic            pc_load;
    srcb_e           srcb_k;
    pcsrc_e          pcsrc_k;

    assign srcb_k  = srcb_e'(srcb_sel);
    assign pcsrc_k = pcsrc_e'(pc_src);

    // holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_next;
            if (ir_we)   ir_q <= mem_rdata[31:0];
            mdr_q    <= mem_rdata;
            a_q      <= rf_a;
            b_q      <= rf_b;
            aluout_q <= alu_res;
        end
    end

    // register file and write-back path
    assign wb_addr = dst_sel ? ir_q[15:11] : ir_q[20:16];
    assign wb_data = wb_sel ? mdr_q : aluout_q;

    dp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (ir_q[25:21]),
        .rd_addr_b (ir_q[20:16]),
        .rd_data_a (rf_a),
        .rd_data_b (rf_b),
        .wr_en     (rf_we),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data)
    );

    // operand selection
    assign imm_ext = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
    assign opnd_a  = srca_sel ? a_q : pc_q;

    always_comb begin
        unique case (srcb_k)
            SRCB_REG:    opnd_b = b_q;
            SRCB_FOUR:   opnd_b = XLEN'(4);
            SRCB_IMM:    opnd_b = imm_ext;
            SRCB_IMM_X4: opnd_b = {imm_ext[XLEN-3:0], 2'b00};
            default:     opnd_b = b_q;
        endcase
    end

    dp_alu #(.XLEN(XLEN)) i_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .op      (alu_op_e'(alu_op)),
        .result  (alu_res),
        .is_zero (zero)
    );

    // next PC
    assign jump_tgt = {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};
    assign pc_load  = pc_we | (pc_we_cond & zero);

    always_comb begin
        unique case (pcsrc_k)
            PCS_ALU:    pc_next = alu_res;
            PCS_ALUREG: pc_next = aluout_q;
            PCS_JUMP:   pc_next = jump_tgt;
            default:    pc_next = pc_q;
        endcase
    end

    // outputs
    assign mem_addr  = addr_sel ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign opcode    = ir_q[31:26];
    assign funct     = ir_q[5:0];

    // R2: IR is frozen without its write enable
    a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_we |=> $stable(ir_q));

    // R10: PC holds unless a write or a qualified branch write occurs
    a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_we || (pc_we_cond && zero)) |=> $stable(pc_q));

    // R11: a jump keeps the current region bits
    a_r11_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pcsrc_k == PCS_JUMP) |=> (pc_q[XLEN-1:28] == $past(pc_q[XLEN-1:28])));

    // R5: comparing A against B through subtraction sets zero on equality
    a_r5_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd1 && srca_sel && srcb_k == SRCB_REG) |-> (zero == (a_q == b_q)));

endmodule

// File: tb/test_mc_datapath.sv
module test_mc_datapath;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pc_we, pc_we_cond, addr_sel, ir_we, rf_we, dst_sel, wb_sel, srca_sel;
    logic [1:0]  srcb_sel, pc_src;
    logic [2:0]  alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode, funct;
    logic        zero;

    logic [31:0] mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    mc_datapath i_mc_datapath (
        .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .addr_sel(addr_sel), .ir_we(ir_we), .rf_we(rf_we), .dst_sel(dst_sel),
        .wb_sel(wb_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op),
        .pc_src(pc_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct), .zero(zero)
    );

    function automatic logic [31:0] mk_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        pc_we = 0; pc_we_cond = 0; addr_sel = 0; ir_we = 0; rf_we = 0;
        dst_sel = 0; wb_sel = 0; srca_sel = 0; srcb_sel = 0; alu_op = 0; pc_src = 0;
    endtask

    // put an instruction at the current PC and latch it, then let A/B follow
    task automatic load_ir(input logic [31:0] instr);
        idle();
        mem[exp_pc[9:2]] = instr;
        ir_we = 1; tick(); ir_we = 0;
        tick();
    endtask

    // write v into register k through the MDR path (rt destination)
    task automatic write_reg(input logic [4:0] k, input logic [31:0] v);
        idle();
        mem[exp_pc[9:2]] = mk_r(5'd0, k, 5'd0, 6'd0);
        ir_we = 1; tick(); ir_we = 0;
        mem[exp_pc[9:2]] = v;
        tick();
        rf_we = 1; wb_sel = 1; tick();
        idle();
    endtask

    function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return {31'd0, $signed(a) < $signed(b)};
        endcase
    endfunction

    // watchdog
    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [8];
        logic [31:0] tgt;
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'd5;
        vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h1234_5678;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        exp_pc = 0;
        idle();
        rst_n = 0;
        tick(); tick(); tick();
        // R1: reset state
        check("R1 pc", mem_addr, 32'h0);
        check("R1 opcode", {26'd0, opcode}, 32'h0);
        check("R1 funct", {26'd0, funct}, 32'h0);
        check("R1 B", mem_wdata, 32'h0);
        addr_sel = 1; #1;
        check("R1 alu reg", mem_addr, 32'h0);
        addr_sel = 0;
        rst_n = 1;

        // R4/R5/R8: ALU sweep over operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                write_reg(5'd1, vals[i]);
                write_reg(5'd2, vals[j]);
                load_ir(mk_r(5'd1, 5'd2, 5'd3, 6'h20));
                check("R8 B operand", mem_wdata, vals[j]);
                for (int op = 0; op < 5; op++) begin
                    alu_op = 3'(op); srca_sel = 1; srcb_sel = 0; addr_sel = 0;
                    #1;
                    if (op == 1) check("R5 zero flag", {31'd0, zero}, {31'd0, vals[i] == vals[j]});
                    tick();
                    addr_sel = 1; #1;
                    check("R4 alu result", mem_addr, ref_alu(op, vals[i], vals[j]));
                    addr_sel = 0;
                end
            end
        end

        // R6: register 0 ignores writes
        write_reg(5'd0, 32'hDEAD_BEEF);
        load_ir(mk_r(5'd0, 5'd0, 5'd0, 6'd0));
        check("R6 reg0 read", mem_wdata, 32'h0);
        srca_sel = 1; srcb_sel = 0; alu_op = 0; tick();
        addr_sel = 1; #1;
        check("R6 reg0 sum", mem_addr, 32'h0);

        // R7: rd destination with ALU write-back, rt left alone
        write_reg(5'd1, 32'd100);
        write_reg(5'd2, 32'd23);
        load_ir(mk_r(5'd1, 5'd2, 5'd3, 6'h20));
        srca_sel = 1; srcb_sel = 0; alu_op = 0; tick();
        rf_we = 1; dst_sel = 1; wb_sel = 0; tick();
        load_ir(mk_r(5'd3, 5'd2, 5'd0, 6'd0));
        check("R7 rt untouched", mem_wdata, 32'd23);
        srca_sel = 1; srcb_sel = 0; alu_op = 0; tick();
        addr_sel = 1; #1;
        check("R7 rd written", mem_addr, 32'd146);

        // R3/R12: data access through the ALU result register and MDR
        write_reg(5'd1, 32'h40);
        write_reg(5'd2, 32'h0);
        load_ir(mk_r(5'd1, 5'd2, 5'd0, 6'h20));
        srca_sel = 1; srcb_sel = 0; alu_op = 0; tick();
        addr_sel = 1; #1;
        check("R3 data address", mem_addr, 32'h40);
        mem[16] = 32'hCAFE_F00D;
        tick();
        rf_we = 1; wb_sel = 1; dst_sel = 0; tick();
        load_ir(mk_r(5'd0, 5'd2, 5'd0, 6'd0));
        check("R12 mdr load", mem_wdata, 32'hCAFE_F00D);

        // R9: operand selects with a negative immediate
        load_ir(mk_i(6'h23, 5'd0, 5'd0, 16'hFFF0));
        check("R2 opcode", {26'd0, opcode}, 32'h23);
        srca_sel = 0; alu_op = 0;
        srcb_sel = 2; tick(); addr_sel = 1; #1;
        check("R9 sext imm", mem_addr, exp_pc + 32'hFFFF_FFF0);
        addr_sel = 0; srcb_sel = 3; tick(); addr_sel = 1; #1;
        check("R9 imm x4", mem_addr, exp_pc + 32'hFFFF_FFC0);
        addr_sel = 0; srcb_sel = 1; tick(); addr_sel = 1; #1;
        check("R9 const four", mem_addr, exp_pc + 32'd4);

        // R2: IR holds without enable, then loads
        idle();
        mem[exp_pc[9:2]] = mk_r(5'd0, 5'd0, 5'd0, 6'h2A);
        tick();
        check("R2 ir hold", {26'd0, opcode}, 32'h23);
        ir_we = 1; tick(); ir_we = 0;
        check("R2 ir load opcode", {26'd0, opcode}, 32'h0);
        check("R2 ir load funct", {26'd0, funct}, 32'h2A);

        // R10: branch not taken then taken
        for (int t = 0; t < 2; t++) begin
            write_reg(5'd1, 32'd7);
            write_reg(5'd2, (t == 0) ? 32'd9 : 32'd7);
            idle();
            mem[exp_pc[9:2]] = mk_i(6'h04, 5'd1, 5'd2, 16'd3);
            ir_we = 1; pc_we = 1; pc_src = 0; srca_sel = 0; srcb_sel = 1; alu_op = 0;
            tick();
            idle();
            exp_pc = exp_pc + 4;
            check("R10 pc increment", mem_addr, exp_pc);
            tgt = exp_pc + 32'd12;
            srca_sel = 0; srcb_sel = 3; alu_op = 0; tick();
            srca_sel = 1; srcb_sel = 0; alu_op = 1; pc_we_cond = 1; pc_src = 1;
            #1;
            check("R10 zero before branch", {31'd0, zero}, {31'd0, t == 1});
            tick();
            idle(); #1;
            if (t == 1) exp_pc = tgt;
            check("R10 branch pc", mem_addr, exp_pc);
        end

        // R11: jump from a PC with nonzero region bits
        write_reg(5'd1, 32'hA000_0000);
        write_reg(5'd2, 32'h0);
        load_ir(mk_r(5'd1, 5'd2, 5'd0, 6'h20));
        srca_sel = 1; srcb_sel = 0; alu_op = 0; tick();
        pc_we = 1; pc_src = 1; tick();
        idle(); #1;
        exp_pc = 32'hA000_0000;
        check("R11 pc from alu reg", mem_addr, exp_pc);
        load_ir({6'h02, 26'h0AB_CDEF});
        pc_we = 1; pc_src = 2; tick();
        idle(); #1;
        exp_pc = {exp_pc[31:28], 26'h0AB_CDEF, 2'b00};
        check("R11 jump target", mem_addr, exp_pc);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule